// File: doc/BRIEF.md
# Interleaved Task Slot Scheduler

This block picks, on every clock, which of up to eight hardware tasks in one processor core owns the next instruction slot. Started tasks take their turns in round-robin order, and tasks that were never started, or were stopped, take no slots at all. A task can be put to sleep until a condition holds. The condition is either a match of the free-running system counter against a stored target, or a masked comparison of the pin vector against stored data, for equal or for not equal. The block keeps each sleeping task's condition in its own registers and wakes the task when the condition is met.

A mode input sets how sleepers are treated. In the fixed-slot mode a sleeping task keeps its turn and the slot goes out as a NOP, so with N started tasks every task owns exactly one of every N slots, whether it is awake or not. In the hand-over mode the turns of sleepers go to the tasks that are awake. If every started task is asleep in that mode, the core idles until one of them wakes. The decoder reads the chosen task index and a real-issue flag from registered outputs.

Top module: `task_slot_sched`

## Requirements
- R1: After each slot the turn passes to the next eligible task in ascending index order, wrapping from the highest index back to 0. The search starts just after the task that owned the previous slot.
- R2: A wait of kind 1 (counter) stores a target and clears sleep once `count_i` equals the target.
- R3: A wait of kind 2 (pin equal) stores a mask in arg A and data in arg B. It clears sleep once `(pins_i & mask) == data`.
- R4: A wait of kind 3 (pin not-equal) clears sleep once `(pins_i & mask) != data`. A wait of kind 0 is ignored.
- R5: With `skip_sleep_i`=0, a sleeping started task keeps its turn: `slot_valid_o`=1 and `slot_issue_o`=0 in its slot. Every started task gets one slot in every N, where N is the number of started tasks. `slot_issue_o`=1 only when `slot_valid_o`=1.
- R6: With `skip_sleep_i`=1, only awake started tasks are given slots. If every started task is asleep, the slot shows `slot_valid_o`=0 and `slot_issue_o`=0, and `slot_task_o` keeps its previous value.
- R7: A task that is not started is never selected. With no task started, `slot_valid_o`=0.
- R8: The condition registers of a task load only on a wait command for that task. Changes on the argument inputs without a wait command leave a sleeping task's condition unchanged.
- R9: With a single started task asleep in the fixed-slot mode, every slot goes to that task as a NOP until its condition is met. This stalls the core.
- R10: Commands and wake conditions seen in the cycle before a clock edge update task state at that edge. A slot decision at an edge uses the state from before the edge. So a wake seen in one cycle makes the task eligible from the following decision onward.
- R11: Stop clears both the started and the sleeping state of a task. Start makes a task started and awake. For the same task, stop takes priority over start, and start over wait. A wait command for a task that is not started is ignored.
- R12: During reset no task is started, `slot_valid_o`=0, `slot_issue_o`=0 and `slot_task_o`=N-1, so the first slot after reset is searched from task 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| skip_sleep_i | input | 1 | 0: sleepers keep their slot as NOP; 1: their slots go to awake tasks |
| count_i | input | CNT_W | System counter value |
| pins_i | input | PIN_W | Pin state vector |
| start_valid_i | input | 1 | Start command |
| start_id_i | input | IW | Task to start |
| stop_valid_i | input | 1 | Stop command |
| stop_id_i | input | IW | Task to stop |
| wait_valid_i | input | 1 | Wait command |
| wait_id_i | input | IW | Task entering the wait |
| wait_kind_i | input | 2 | 0 none, 1 counter, 2 pin equal, 3 pin not-equal |
| wait_arg_a_i | input | ARG_W | Counter target or pin mask |
| wait_arg_b_i | input | ARG_W | Pin data |
| slot_valid_o | output | 1 | A task owns this slot |
| slot_task_o | output | IW | Index of the owning task |
| slot_issue_o | output | 1 | 1 for a real issue, 0 for a NOP |

## Verification
The hardest state to reach from the ports is the hand-over mode with every started task asleep at the same time, and then waking exactly one of them. It takes counter waits on all started tasks with targets close together, each command placed while the other tasks are still running. The bench builds this state directly, with shared targets a few counts ahead. A long random phase then mixes starts, stops, waits with near-future counter targets and pin conditions on a narrow pin field, and toggles the mode periodically, so that wakes, re-arms and stops of sleeping tasks collide in the same cycles.

// File: rtl/task_sched_pkg.sv
package task_sched_pkg;
  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_COUNT  = 2'd1,
    WK_PIN_EQ = 2'd2,
    WK_PIN_NE = 2'd3
  } wait_kind_e;
endpackage

// File: rtl/task_wait_cell.sv
module task_wait_cell
  import task_sched_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PIN_W = 32,
  parameter int ARG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             wait_i,
  input  logic [1:0]       kind_i,
  input  logic [ARG_W-1:0] arg_a_i,
  input  logic [ARG_W-1:0] arg_b_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [PIN_W-1:0] pins_i,
  output logic             active_o,
  output logic             asleep_o
);
  logic             active_q, asleep_q, load, met;
  wait_kind_e       kind_q;
  logic [ARG_W-1:0] a_q, b_q;

  assign load = wait_i & active_q & ~start_i & ~stop_i;

  always_comb begin
    unique case (kind_q)
      WK_COUNT:  met = (count_i == a_q[CNT_W-1:0]);
      WK_PIN_EQ: met = ((pins_i & a_q[PIN_W-1:0]) == b_q[PIN_W-1:0]);
      WK_PIN_NE: met = ((pins_i & a_q[PIN_W-1:0]) != b_q[PIN_W-1:0]);
      default:   met = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      asleep_q <= 1'b0;
    end else if (stop_i) begin
      active_q <= 1'b0;
      asleep_q <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      asleep_q <= 1'b0;
    end else if (load) begin
      asleep_q <= 1'b1;
    end else if (asleep_q && met) begin
      asleep_q <= 1'b0;
    end
  end

  // condition storage: enabled only on entry, clock-gateable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= WK_NONE;
      a_q    <= '0;
      b_q    <= '0;
    end else if (load) begin
      kind_q <= wait_kind_e'(kind_i);
      a_q    <= arg_a_i;
      b_q    <= arg_b_i;
    end
  end

  assign active_o = active_q;
  assign asleep_o = asleep_q;

  assert_sleep_needs_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_q |-> active_q);
  assert_stop_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!active_q && !asleep_q));
  assert_wake_on_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_q && met && !wait_i && !start_i && !stop_i) |=> !asleep_q);
  assert_sleep_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_q && !met && !wait_i && !start_i && !stop_i) |=> asleep_q);
endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          found_o,
  output logic [IW-1:0] pick_o
);
  always_comb begin
    found_o = 1'b0;
    pick_o  = last_i;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = int'(last_i) + k;
      if (idx >= N) idx = idx - N;
      if (!found_o && req_i[idx]) begin
        found_o = 1'b1;
        pick_o  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/task_slot_sched.sv
module task_slot_sched
  import task_sched_pkg::*;
#(
  parameter int N     = 8,
  parameter int CNT_W = 32,
  parameter int PIN_W = 32,
  localparam int IW    = (N > 1) ? $clog2(N) : 1,
  localparam int ARG_W = (CNT_W > PIN_W) ? CNT_W : PIN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             skip_sleep_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [PIN_W-1:0] pins_i,
  input  logic             start_valid_i,
  input  logic [IW-1:0]    start_id_i,
  input  logic             stop_valid_i,
  input  logic [IW-1:0]    stop_id_i,
  input  logic             wait_valid_i,
  input  logic [IW-1:0]    wait_id_i,
  input  logic [1:0]       wait_kind_i,
  input  logic [ARG_W-1:0] wait_arg_a_i,
  input  logic [ARG_W-1:0] wait_arg_b_i,
  output logic             slot_valid_o,
  output logic [IW-1:0]    slot_task_o,
  output logic             slot_issue_o
);
  logic [N-1:0]  active, asleep, cand;
  logic          found;
  logic [IW-1:0] pick, last_q;
  logic          valid_q, issue_q;

  for (genvar t = 0; t < N; t++) begin : g_task
    task_wait_cell #(.CNT_W(CNT_W), .PIN_W(PIN_W), .ARG_W(ARG_W)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_valid_i && (start_id_i == IW'(t))),
      .stop_i   (stop_valid_i && (stop_id_i == IW'(t))),
      .wait_i   (wait_valid_i && (wait_id_i == IW'(t)) && (wait_kind_i != WK_NONE)),
      .kind_i   (wait_kind_i),
      .arg_a_i  (wait_arg_a_i),
      .arg_b_i  (wait_arg_b_i),
      .count_i  (count_i),
      .pins_i   (pins_i),
      .active_o (active[t]),
      .asleep_o (asleep[t])
    );
  end

  assign cand = skip_sleep_i ? (active & ~asleep) : active;

  rr_picker #(.N(N), .IW(IW)) u_pick (
    .req_i   (cand),
    .last_i  (last_q),
    .found_o (found),
    .pick_o  (pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= IW'(N - 1);
      valid_q <= 1'b0;
      issue_q <= 1'b0;
    end else if (found) begin
      last_q  <= pick;
      valid_q <= 1'b1;
      issue_q <= ~asleep[pick];
    end else begin
      valid_q <= 1'b0;
      issue_q <= 1'b0;
    end
  end

  assign slot_valid_o = valid_q;
  assign slot_task_o  = last_q;
  assign slot_issue_o = issue_q;

  assert_empty_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active == '0) |=> !slot_valid_o);
  assert_det_keeps_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!skip_sleep_i && active != '0) |=> slot_valid_o);
  assert_issue_needs_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_issue_o |-> slot_valid_o);
  assert_skip_awake_issues_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_sleep_i && (active & ~asleep) != '0) |=> slot_issue_o);
  assert_all_asleep_nop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_sleep_i && (active & ~asleep) == '0) |=> (!slot_valid_o && !slot_issue_o));
endmodule

// File: tb/task_slot_sched_tb.sv
module task_slot_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        skip_sleep_i = 1'b0;
  logic [31:0] count_i = '0, pins_i = '0;
  logic        start_valid_i = 1'b0, stop_valid_i = 1'b0, wait_valid_i = 1'b0;
  logic [2:0]  start_id_i = '0, stop_id_i = '0, wait_id_i = '0;
  logic [1:0]  wait_kind_i = '0;
  logic [31:0] wait_arg_a_i = '0, wait_arg_b_i = '0;
  logic        slot_valid_o, slot_issue_o;
  logic [2:0]  slot_task_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task_slot_sched u_dut (.*);

  int    checks = 0, errors = 0, cycles = 0;
  string cur_req = "R12";

  // reference model
  logic [N-1:0] m_act, m_slp;
  logic [1:0]   m_kind [N];
  logic [31:0]  m_a [N], m_b [N];
  logic [2:0]   m_last;
  logic         e_valid, e_issue;
  logic [2:0]   e_task;

  function automatic logic cond_met(int i);
    case (m_kind[i])
      2'd1:    return count_i == m_a[i];
      2'd2:    return (pins_i & m_a[i]) == m_b[i];
      2'd3:    return (pins_i & m_a[i]) != m_b[i];
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act = '0; m_slp = '0; m_last = 3'(N-1);
      e_valid = 0; e_issue = 0; e_task = 3'(N-1);
      for (int i = 0; i < N; i++) begin m_kind[i] = 0; m_a[i] = 0; m_b[i] = 0; end
    end else begin
      logic [N-1:0] cand, met;
      logic         fnd;
      cand = skip_sleep_i ? (m_act & ~m_slp) : m_act;
      fnd = 0;
      for (int k = 1; k <= N; k++) begin
        int idx;
        idx = (int'(m_last) + k) % N;
        if (!fnd && cand[idx]) begin fnd = 1; m_last = 3'(idx); end
      end
      e_valid = fnd;
      e_issue = fnd && !m_slp[m_last];
      e_task  = m_last;
      for (int i = 0; i < N; i++) met[i] = cond_met(i);
      for (int i = 0; i < N; i++) begin
        if (stop_valid_i && stop_id_i == 3'(i)) begin m_act[i] = 0; m_slp[i] = 0; end
        else if (start_valid_i && start_id_i == 3'(i)) begin m_act[i] = 1; m_slp[i] = 0; end
        else if (wait_valid_i && wait_id_i == 3'(i) && wait_kind_i != 0 && m_act[i]) begin
          m_slp[i] = 1; m_kind[i] = wait_kind_i; m_a[i] = wait_arg_a_i; m_b[i] = wait_arg_b_i;
        end else if (m_slp[i] && met[i]) m_slp[i] = 0;
      end
    end
  end

  task automatic check_out();
    checks++;
    if (slot_valid_o !== e_valid || slot_issue_o !== e_issue || slot_task_o !== e_task) begin
      errors++;
      $display("FAIL %s: valid/issue/task got %0b/%0b/%0d expected %0b/%0b/%0d",
               cur_req, slot_valid_o, slot_issue_o, slot_task_o, e_valid, e_issue, e_task);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk_i);
      check_out();
      count_i = count_i + 1;
    end
  endtask

  task automatic do_start(int id);
    start_valid_i = 1; start_id_i = 3'(id); tick(1); start_valid_i = 0;
  endtask
  task automatic do_stop(int id);
    stop_valid_i = 1; stop_id_i = 3'(id); tick(1); stop_valid_i = 0;
  endtask
  task automatic do_wait(int id, int kind, logic [31:0] a, logic [31:0] b);
    wait_valid_i = 1; wait_id_i = 3'(id); wait_kind_i = 2'(kind);
    wait_arg_a_i = a; wait_arg_b_i = b;
    tick(1); wait_valid_i = 0;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    cur_req = "R12"; tick(2);
    rst_ni = 1;
    cur_req = "R7";  tick(3);
    cur_req = "R1";  do_start(0); do_start(2); do_start(5); tick(9);
    cur_req = "R5";  do_wait(2, 1, count_i + 6, 0); tick(3);
    cur_req = "R2";  tick(6);
    cur_req = "R6";  skip_sleep_i = 1; do_wait(0, 1, count_i + 4, 0); tick(8);
    do_wait(0, 1, count_i + 11, 0); do_wait(2, 1, count_i + 10, 0);
    do_wait(5, 1, count_i + 9, 0); tick(12);
    cur_req = "R11"; do_stop(0); do_stop(2); do_stop(5); tick(2);
    do_wait(4, 1, count_i + 2, 0); tick(3);
    cur_req = "R9";  skip_sleep_i = 0; pins_i = 0; do_start(3);
    do_wait(3, 2, 32'hF, 32'h5); tick(4);
    cur_req = "R8";  wait_arg_a_i = 0; wait_arg_b_i = 0; tick(3);
    cur_req = "R3";  pins_i = 32'h5; tick(3);
    cur_req = "R4";  do_wait(3, 3, 32'hF0, 32'h30); pins_i = 32'h35; tick(3);
    pins_i = 32'h15; tick(3);
    do_wait(3, 0, 0, 0); tick(2);
    cur_req = "R10"; do_start(1); do_wait(1, 1, count_i + 3, 0); tick(6);
    cur_req = "R11"; do_wait(3, 1, count_i + 100, 0); tick(2); do_stop(3); do_start(3); tick(4);
    start_valid_i = 1; stop_valid_i = 1; start_id_i = 3'd6; stop_id_i = 3'd6; tick(1);
    start_valid_i = 0; stop_valid_i = 0; tick(3);
    cur_req = "R1";
    for (int c = 0; c < 4000; c++) begin
      if (c % 250 == 0) skip_sleep_i = ~skip_sleep_i;
      start_valid_i = ($urandom % 8) == 0; start_id_i = 3'($urandom);
      stop_valid_i  = ($urandom % 12) == 0; stop_id_i = 3'($urandom);
      wait_valid_i  = ($urandom % 3) == 0; wait_id_i = 3'($urandom);
      wait_kind_i   = 2'($urandom);
      if (wait_kind_i == 2'd1) wait_arg_a_i = count_i + 1 + ($urandom % 12);
      else wait_arg_a_i = $urandom % 16;
      wait_arg_b_i = ($urandom % 16) & (($urandom % 2) ? wait_arg_a_i : 32'hF);
      pins_i = $urandom % 16;
      tick(1);
    end
    start_valid_i = 0; stop_valid_i = 0; wait_valid_i = 0; tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule